// File: doc/BRIEF.md
# Scanline Interrupt Counter

This block counts rendered display lines and raises an interrupt request to the CPU after a programmed number of them. Software sets up the block through four decoded register-write slots. One slot loads the live count. One fills a reload latch. One turns the counter off and clears a pending request. One turns the counter on.

A per-line pulse comes in together with the current line number. The counter only moves on that pulse when three things hold: the line is one of the visible lines 0..239, rendering is switched on, and the counter is enabled. On each qualifying pulse the counter decrements first. If the result is zero, it reloads from the latch and the request is raised. The request then stays high until software acknowledges it.

The block does not make the line pulse and does not arbitrate the CPU interrupt.

Top module: `scanirq_counter`

## Requirements
- R1: A write to slot 0 (wr_slot = 2'd0) loads wr_data into the counter, which shows on count_o after the next clock edge.
- R2: A synchronous reset clears the counter, the reload latch, the enable and the interrupt request.
- R3: On a qualifying line pulse the counter decrements; if the decremented value is 1→0, the counter takes the latch value instead and irq goes high on the same edge.
- R4: A write to slot 2 (wr_slot = 2'd2) clears the enable and drops irq after the next edge.
- R5: Line pulses are ignored unless the line number is at most 239 and render_en is high; line 239 counts and line 240 does not.
- R6: While the enable is clear, line pulses leave the counter unchanged. A write to slot 3 (wr_slot = 2'd3) sets the enable.
- R7: A qualifying pulse with the counter at 0 wraps it to 255 and does not raise irq.
- R8: Once high, irq stays high across further pulses until a slot-2 write or reset.
- R9: When a register write and a line pulse fall in the same cycle, the write is applied and the pulse is dropped.
- R10: A write to slot 1 (wr_slot = 2'd1) loads the reload latch without changing the live count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_slot | input | 2 | Write slot: 0 count, 1 latch, 2 disable/ack, 3 enable |
| wr_data | input | 8 | Write data |
| line_tick | input | 1 | One-cycle pulse per display line |
| line_num | input | 9 | Line number carried with the pulse |
| render_en | input | 1 | Rendering is switched on |
| count_o | output | 8 | Live counter value |
| irq | output | 1 | Interrupt request, held until acknowledged |

## Verification
Some behaviour is checked on every cycle by properties:
- the counter holds whenever a pulse is unqualified or the enable is clear;
- a rise of irq always follows a qualified pulse at count 1;
- irq stays high until a disable write;
- a disable write always drops irq;
- a qualified pulse at zero wraps to 255.

Other behaviour only shows up in the bench's scenarios, because it depends on sequences of register writes and line numbers:
- which value the latch supplies on reload;
- that a simultaneous write wins over a pulse;
- the exact 239/240 boundary;
- the state left by reset.

// File: rtl/scanirq_pkg.sv
package scanirq_pkg;

    localparam int CNT_W        = 8;
    localparam int LINE_W       = 9;
    localparam int LAST_VISIBLE = 239;

    typedef enum logic [1:0] {
        SLOT_COUNT   = 2'd0,
        SLOT_LATCH   = 2'd1,
        SLOT_DISABLE = 2'd2,
        SLOT_ENABLE  = 2'd3
    } slot_e;

    typedef struct packed {
        logic              ld_count;
        logic              ld_latch;
        logic              dis;
        logic              ena;
        logic [CNT_W-1:0]  data;
    } wr_cmd_t;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] latch;
        logic             enable;
        logic             irq;
    } ctr_state_t;

    function automatic logic line_visible(input logic [LINE_W-1:0] ln);
        return (ln <= LINE_W'(LAST_VISIBLE));
    endfunction

endpackage

// File: rtl/scanirq_regdec.sv
module scanirq_regdec
    import scanirq_pkg::*;
(
    input  logic             wr_en,
    input  logic [1:0]       wr_slot,
    input  logic [CNT_W-1:0] wr_data,
    output wr_cmd_t          cmd
);
    always_comb begin
        cmd          = '0;
        cmd.data     = wr_data;
        if (wr_en) begin
            unique case (slot_e'(wr_slot))
                SLOT_COUNT:   cmd.ld_count = 1'b1;
                SLOT_LATCH:   cmd.ld_latch = 1'b1;
                SLOT_DISABLE: cmd.dis      = 1'b1;
                SLOT_ENABLE:  cmd.ena      = 1'b1;
                default:      ;
            endcase
        end
    end

    always_comb begin
        if (!wr_en) assert ({cmd.ld_count, cmd.ld_latch, cmd.dis, cmd.ena} == 4'b0);
    end
endmodule

// File: rtl/scanirq_linequal.sv
module scanirq_linequal
    import scanirq_pkg::*;
(
    input  logic              line_tick,
    input  logic [LINE_W-1:0] line_num,
    input  logic              render_en,
    input  logic              any_write,
    output logic              step
);
    // a register write in the same cycle wins: the pulse is dropped
    assign step = line_tick && render_en && line_visible(line_num) && !any_write;
endmodule

// File: rtl/scanirq_core.sv
module scanirq_core
    import scanirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  wr_cmd_t          cmd,
    input  logic             step,
    output ctr_state_t       st
);
    ctr_state_t       st_n;
    logic [CNT_W-1:0] dec;

    assign dec = st.count - CNT_W'(1);

    always_comb begin
        st_n = st;
        if (cmd.ld_count) st_n.count = cmd.data;
        if (cmd.ld_latch) st_n.latch = cmd.data;
        if (cmd.dis) begin
            st_n.enable = 1'b0;
            st_n.irq    = 1'b0;
        end
        if (cmd.ena) st_n.enable = 1'b1;
        if (step && st.enable) begin
            if (dec == '0) begin
                st_n.count = st.latch;
                st_n.irq   = 1'b1;
            end else begin
                st_n.count = dec;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= st_n;
    end

    AST_DIS_DROPS_IRQ: assert property (@(posedge clk) disable iff (rst)
        cmd.dis |=> !st.irq);                                              // R4
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        st.irq && !cmd.dis |=> st.irq);                                    // R8
    AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !st.enable && !cmd.ld_count |=> $stable(st.count));                // R6
    AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (rst)
        !step && !cmd.ld_count |=> $stable(st.count));                     // R5
    AST_RISE_AT_ONE: assert property (@(posedge clk) disable iff (rst)
        !st.irq ##1 st.irq |-> $past(step && st.enable && st.count == 8'd1)); // R3
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        step && st.enable && st.count == '0 && !st.irq |=> st.count == '1 && !st.irq); // R7
endmodule

// File: rtl/scanirq_counter.sv
module scanirq_counter
    import scanirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_slot,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              line_tick,
    input  logic [LINE_W-1:0] line_num,
    input  logic              render_en,
    output logic [CNT_W-1:0]  count_o,
    output logic              irq
);
    wr_cmd_t    cmd;
    logic       step;
    ctr_state_t st;

    scanirq_regdec u_dec (
        .wr_en   (wr_en),
        .wr_slot (wr_slot),
        .wr_data (wr_data),
        .cmd     (cmd)
    );

    scanirq_linequal u_qual (
        .line_tick (line_tick),
        .line_num  (line_num),
        .render_en (render_en),
        .any_write (wr_en),
        .step      (step)
    );

    scanirq_core u_core (
        .clk  (clk),
        .rst  (rst),
        .cmd  (cmd),
        .step (step),
        .st   (st)
    );

    assign count_o = st.count;
    assign irq     = st.irq;

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_slot == 2'd0 |=> count_o == $past(wr_data));            // R9
endmodule

// File: tb/tb_scanirq_counter.sv
module tb_scanirq_counter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_slot = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       line_tick = 1'b0;
    logic [8:0] line_num = 9'd0;
    logic       render_en = 1'b0;
    logic [7:0] count_o;
    logic       irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    scanirq_counter dut (.*);

    // {is_wr, slot, data, line, render, exp_cnt, exp_irq}
    localparam int NV = 16;
    localparam logic [29:0] VEC [NV] = '{
        {1'b1, 2'd1, 8'd3,   9'd0,   1'b0, 8'd0,   1'b0}, // R10 latch load
        {1'b1, 2'd0, 8'd2,   9'd0,   1'b0, 8'd2,   1'b0}, // R1 count load
        {1'b0, 2'd0, 8'd0,   9'd10,  1'b1, 8'd2,   1'b0}, // R6 disabled hold
        {1'b1, 2'd3, 8'd0,   9'd0,   1'b0, 8'd2,   1'b0}, // R6 enable
        {1'b0, 2'd0, 8'd0,   9'd10,  1'b1, 8'd1,   1'b0}, // R3 decrement
        {1'b0, 2'd0, 8'd0,   9'd240, 1'b1, 8'd1,   1'b0}, // R5 line 240
        {1'b0, 2'd0, 8'd0,   9'd20,  1'b0, 8'd1,   1'b0}, // R5 render off
        {1'b0, 2'd0, 8'd0,   9'd239, 1'b1, 8'd3,   1'b1}, // R3 R5 reload at 239
        {1'b0, 2'd0, 8'd0,   9'd0,   1'b1, 8'd2,   1'b1}, // R8 sticky
        {1'b1, 2'd2, 8'd0,   9'd0,   1'b0, 8'd2,   1'b0}, // R4 ack
        {1'b0, 2'd0, 8'd0,   9'd5,   1'b1, 8'd2,   1'b0}, // R6 disabled
        {1'b1, 2'd3, 8'd0,   9'd0,   1'b0, 8'd2,   1'b0}, // R6 enable
        {1'b1, 2'd0, 8'd0,   9'd0,   1'b0, 8'd0,   1'b0}, // R1 load 0
        {1'b0, 2'd0, 8'd0,   9'd1,   1'b1, 8'd255, 1'b0}, // R7 wrap
        {1'b1, 2'd0, 8'd1,   9'd0,   1'b0, 8'd1,   1'b0}, // R1 load 1
        {1'b0, 2'd0, 8'd0,   9'd2,   1'b1, 8'd3,   1'b1}  // R3 reload
    };

    task automatic check(input string req, input logic [7:0] gc, input logic gi,
                         input logic [7:0] ec, input logic ei);
        checks++;
        if (gc !== ec || gi !== ei) begin
            errors++;
            $display("FAIL %s: count=%0d irq=%0b expected count=%0d irq=%0b",
                     req, gc, gi, ec, ei);
        end
    endtask

    task automatic step_cycle(input logic w, input logic [1:0] s, input logic [7:0] d,
                              input logic t, input logic [8:0] ln, input logic r);
        wr_en = w; wr_slot = s; wr_data = d;
        line_tick = t; line_num = ln; render_en = r;
        @(posedge clk);
        #1;
        wr_en = 1'b0; line_tick = 1'b0;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        check("R2 reset state", count_o, irq, 8'd0, 1'b0);
        for (int i = 0; i < NV; i++) begin
            step_cycle(VEC[i][29], VEC[i][28:27], VEC[i][26:19],
                       !VEC[i][29], VEC[i][18:10], VEC[i][9]);
            check($sformatf("vector %0d (R1..R10 table)", i), count_o, irq,
                  VEC[i][8:1], VEC[i][0]);
        end
        // R9: write coincident with a qualifying pulse: write wins, pulse dropped
        step_cycle(1'b1, 2'd1, 8'd9, 1'b1, 9'd3, 1'b1);
        check("R9 write beats pulse", count_o, irq, 8'd3, 1'b1);
        step_cycle(1'b1, 2'd0, 8'd7, 1'b1, 9'd3, 1'b1);
        check("R9 count write beats pulse", count_o, irq, 8'd7, 1'b1);
        // R2: reset clears everything, including enable and latch
        rst = 1'b1;
        @(posedge clk); #1;
        rst = 1'b0;
        check("R2 reset clears", count_o, irq, 8'd0, 1'b0);
        step_cycle(1'b1, 2'd0, 8'd5, 1'b0, 9'd0, 1'b0);
        step_cycle(1'b0, 2'd0, 8'd0, 1'b1, 9'd4, 1'b1);
        check("R2 enable cleared by reset", count_o, irq, 8'd5, 1'b0);
        step_cycle(1'b1, 2'd3, 8'd0, 1'b0, 9'd0, 1'b0);
        step_cycle(1'b1, 2'd0, 8'd1, 1'b0, 9'd0, 1'b0);
        step_cycle(1'b0, 2'd0, 8'd0, 1'b1, 9'd4, 1'b1);
        check("R2 latch cleared by reset", count_o, irq, 8'd0, 1'b1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule